// File: doc/BRIEF.md
# Programmable Raster Sync Timing Generator

This block paces the readout of a pixel raster. A clock enable marks each pixel slot. On each enabled cycle the block moves one column along the current line. At the end of a line it moves to the next row, and after the last row it returns to the top of the frame. For the position it has just reached, the block reports the column and row, a frame sync (`vsync`), a line sync (`hsync`) and a pixel qualifier (`data_valid`). All outputs are registered and stay unchanged while the enable is low.

Software sets the geometry through a flat configuration input:
- visible columns and horizontal blanking, which together give the line length;
- visible rows and vertical blanking, which together give the frame length;
- where the line sync starts and how long it lasts, in pixel slots;
- where the frame sync starts and how many rows it lasts;
- the first row that carries image data. Rows above it are dark reference rows.

A mode bit changes the line sync from a fixed-width pulse into a window that follows the valid pixels. The block copies the configuration into a shadow set while reset is held and again at each frame wrap. A frame therefore never mixes two settings.

Top module: `raster_timing_gen`

## Requirements
- R1: While `rst_n` is low, each clock edge clears `col`, `row`, `hsync`, `vsync` and `data_valid` to zero and copies the configuration inputs into the shadow set.
- R2: Each clock edge with `pix_en` high sets the reported position to the next slot. `col` counts 0 to `cfg_act_w + cfg_hblank - 1` and then returns to 0. The first enabled edge after reset reports column 0, row 0.
- R3: `row` increments when `col` wraps. After row `cfg_act_h + cfg_vblank - 1` it returns to 0.
- R4: With `cfg_hs_valid_mode` = 0, `hsync` is 1 exactly when `cfg_hs_start <= col < cfg_hs_start + cfg_hs_width`. This holds on every row.
- R5: With `cfg_hs_valid_mode` = 1, `hsync` equals `data_valid` at every position.
- R6: `vsync` is 1 exactly when `cfg_vs_start <= row < cfg_vs_start + cfg_vs_width`. This holds at every column.
- R7: `data_valid` is 1 exactly when `col < cfg_act_w` and `cfg_first_row <= row < cfg_first_row + cfg_act_h`.
- R8: On a clock edge with `pix_en` low, all five outputs keep their values.
- R9: A configuration change takes effect only after the frame wrap (last column of the last row to column 0, row 0). A change during a frame has no effect on the rest of that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-domain clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pix_en | input | 1 | Pixel slot enable; advances the raster |
| cfg_act_w | input | 16 | Visible columns per line |
| cfg_hblank | input | 16 | Blanking columns per line |
| cfg_hs_start | input | 16 | Column where the line sync pulse begins |
| cfg_hs_width | input | 8 | Line sync pulse length in pixel slots |
| cfg_hs_valid_mode | input | 1 | 1: line sync marks valid pixels; 0: pulse |
| cfg_act_h | input | 13 | Image rows per frame |
| cfg_vblank | input | 13 | Extra rows per frame |
| cfg_first_row | input | 13 | First row that carries image data |
| cfg_vs_start | input | 13 | Row where the frame sync begins |
| cfg_vs_width | input | 8 | Frame sync length in rows |
| hsync | output | 1 | Line sync or line-valid window |
| vsync | output | 1 | Frame sync |
| data_valid | output | 1 | Current position holds image data |
| col | output | 16 | Reported column |
| row | output | 13 | Reported row |

## Verification
The checks on the output window assume two things about the configuration. First, the image rows end before the last row of the frame (`cfg_first_row < cfg_vblank`). Second, the line and the frame each last at least two slots. Under these conditions `data_valid` is never high at the position reported across a frame wrap, which is the only time the shadow set and the reported outputs may refer to different settings. Every configuration the stimulus programs keeps to these limits. The stimulus changes settings in the middle of a frame, runs the enable both continuously and in random patterns, places the line sync pulse on the last column, and applies reset in the middle of a run.

// File: rtl/raster_pkg.sv
// Shared widths and the configuration record of the raster timing generator.
// Assumes: all raster modules import this package and take their widths from it.
package raster_pkg;
    parameter int unsigned RG_COL_W = 16;
    parameter int unsigned RG_ROW_W = 13;
    parameter int unsigned RG_HSW_W = 8;
    parameter int unsigned RG_VSW_W = 8;

    typedef struct packed {
        logic [RG_COL_W-1:0] act_w;
        logic [RG_COL_W-1:0] hblank;
        logic [RG_COL_W-1:0] hs_start;
        logic [RG_HSW_W-1:0] hs_width;
        logic                hs_valid_mode;
        logic [RG_ROW_W-1:0] act_h;
        logic [RG_ROW_W-1:0] vblank;
        logic [RG_ROW_W-1:0] first_row;
        logic [RG_ROW_W-1:0] vs_start;
        logic [RG_VSW_W-1:0] vs_width;
    } raster_cfg_t;
endpackage

// File: rtl/raster_cfg_shadow.sv
// Holds the configuration for the frame in progress.
// Copies the live configuration while reset is held and on each frame wrap.
// Assumes: load is a single-cycle strobe that is high only on the enabled wrap edge.
module raster_cfg_shadow
    import raster_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  raster_cfg_t cfg_in,
    output raster_cfg_t cfg_q
);
    // Purpose: capture the settings that the next frame will use.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            cfg_q <= cfg_in;
        end
    end
endmodule

// File: rtl/raster_pos_counter.sv
// Column and row counters that walk the raster.
// Reports when the current slot is the last slot of the frame.
// Assumes: the line length and the frame length are each at least one.
module raster_pos_counter
    import raster_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pix_en,
    input  raster_cfg_t         cfg,
    output logic [RG_COL_W-1:0] cnt_col,
    output logic [RG_ROW_W-1:0] cnt_row,
    output logic                frame_end
);
    localparam int LW = RG_COL_W + 1;
    localparam int FW = RG_ROW_W + 1;

    logic [LW-1:0] line_len;
    logic [FW-1:0] frame_len;
    logic          line_end;

    // Purpose: find the line and frame lengths and detect the last slots.
    always_comb begin
        line_len  = LW'(cfg.act_w) + LW'(cfg.hblank);
        frame_len = FW'(cfg.act_h) + FW'(cfg.vblank);
        line_end  = (LW'(cnt_col) + LW'(1)) >= line_len;
        frame_end = line_end && ((FW'(cnt_row) + FW'(1)) >= frame_len);
    end

    // Purpose: advance the position by one slot on each enabled cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_col <= '0;
            cnt_row <= '0;
        end else if (pix_en) begin
            if (line_end) begin
                cnt_col <= '0;
                cnt_row <= frame_end ? '0 : cnt_row + 1'b1;
            end else begin
                cnt_col <= cnt_col + 1'b1;
            end
        end
    end
endmodule

// File: rtl/raster_sync_gen.sv
// Decodes the sync and valid levels for the counter position.
// Registers them, together with that position, on each enabled cycle.
// Assumes: cfg describes the frame that the counter position belongs to.
module raster_sync_gen
    import raster_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pix_en,
    input  raster_cfg_t         cfg,
    input  logic [RG_COL_W-1:0] cnt_col,
    input  logic [RG_ROW_W-1:0] cnt_row,
    output logic [RG_COL_W-1:0] out_col,
    output logic [RG_ROW_W-1:0] out_row,
    output logic                hsync,
    output logic                vsync,
    output logic                data_valid
);
    localparam int WW = 32;

    // Purpose: test whether pos lies in the half-open window [start, start+len).
    function automatic logic in_window(input logic [WW-1:0] pos,
                                       input logic [WW-1:0] start,
                                       input logic [WW-1:0] len);
        return (pos >= start) && (pos < start + len);
    endfunction

    logic hs_pulse;
    logic h_act;
    logic v_act;
    logic vs_lvl;
    logic dv_lvl;
    logic hs_lvl;

    // Purpose: decode the window levels for the current position.
    always_comb begin
        hs_pulse = in_window(WW'(cnt_col), WW'(cfg.hs_start), WW'(cfg.hs_width));
        h_act    = in_window(WW'(cnt_col), '0, WW'(cfg.act_w));
        v_act    = in_window(WW'(cnt_row), WW'(cfg.first_row), WW'(cfg.act_h));
        vs_lvl   = in_window(WW'(cnt_row), WW'(cfg.vs_start), WW'(cfg.vs_width));
        dv_lvl   = h_act && v_act;
        hs_lvl   = cfg.hs_valid_mode ? dv_lvl : hs_pulse;
    end

    // Purpose: register the position and its levels; hold them while the enable is low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_col    <= '0;
            out_row    <= '0;
            hsync      <= 1'b0;
            vsync      <= 1'b0;
            data_valid <= 1'b0;
        end else if (pix_en) begin
            out_col    <= cnt_col;
            out_row    <= cnt_row;
            hsync      <= hs_lvl;
            vsync      <= vs_lvl;
            data_valid <= dv_lvl;
        end
    end
endmodule

// File: rtl/raster_timing_gen.sv
// Top of the raster sync timing generator.
// Connects the configuration shadow, the position counters and the sync decoder.
// Assumes: first_row < vblank, and the line and the frame each last at least two slots.
module raster_timing_gen
    import raster_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pix_en,
    input  logic [RG_COL_W-1:0] cfg_act_w,
    input  logic [RG_COL_W-1:0] cfg_hblank,
    input  logic [RG_COL_W-1:0] cfg_hs_start,
    input  logic [RG_HSW_W-1:0] cfg_hs_width,
    input  logic                cfg_hs_valid_mode,
    input  logic [RG_ROW_W-1:0] cfg_act_h,
    input  logic [RG_ROW_W-1:0] cfg_vblank,
    input  logic [RG_ROW_W-1:0] cfg_first_row,
    input  logic [RG_ROW_W-1:0] cfg_vs_start,
    input  logic [RG_VSW_W-1:0] cfg_vs_width,
    output logic                hsync,
    output logic                vsync,
    output logic                data_valid,
    output logic [RG_COL_W-1:0] col,
    output logic [RG_ROW_W-1:0] row
);
    raster_cfg_t         live_cfg;
    raster_cfg_t         act_cfg;
    logic [RG_COL_W-1:0] cnt_col;
    logic [RG_ROW_W-1:0] cnt_row;
    logic                frame_end;
    logic                wrap_load;

    // Purpose: gather the configuration pins into one record.
    always_comb begin
        live_cfg.act_w         = cfg_act_w;
        live_cfg.hblank        = cfg_hblank;
        live_cfg.hs_start      = cfg_hs_start;
        live_cfg.hs_width      = cfg_hs_width;
        live_cfg.hs_valid_mode = cfg_hs_valid_mode;
        live_cfg.act_h         = cfg_act_h;
        live_cfg.vblank        = cfg_vblank;
        live_cfg.first_row     = cfg_first_row;
        live_cfg.vs_start      = cfg_vs_start;
        live_cfg.vs_width      = cfg_vs_width;
        wrap_load              = pix_en && frame_end;
    end

    raster_cfg_shadow u_shadow (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (wrap_load),
        .cfg_in (live_cfg),
        .cfg_q  (act_cfg)
    );

    raster_pos_counter u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .pix_en    (pix_en),
        .cfg       (act_cfg),
        .cnt_col   (cnt_col),
        .cnt_row   (cnt_row),
        .frame_end (frame_end)
    );

    raster_sync_gen u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .pix_en     (pix_en),
        .cfg        (act_cfg),
        .cnt_col    (cnt_col),
        .cnt_row    (cnt_row),
        .out_col    (col),
        .out_row    (row),
        .hsync      (hsync),
        .vsync      (vsync),
        .data_valid (data_valid)
    );
endmodule

// File: rtl/raster_timing_chk.sv
// Property checker for raster_timing_gen, attached by the bind below.
// Assumes: the configuration limits listed in the header of the top module.
module raster_timing_chk
    import raster_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                pix_en,
    input raster_cfg_t         act_cfg,
    input logic                hsync,
    input logic                vsync,
    input logic                data_valid,
    input logic [RG_COL_W-1:0] col,
    input logic [RG_ROW_W-1:0] row
);
    // R1: the first edge after reset has left every output at zero.
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (col == '0 && row == '0 && !hsync && !vsync && !data_valid));

    // R2: within a line, the column steps by exactly one.
    a_r2_col_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(pix_en) && col != '0) |-> (col == $past(col) + 1'b1));

    // R3: the row changes only when the column wraps to zero.
    a_r3_row_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && col != '0) |-> (row == $past(row)));

    // R7: valid pixels lie inside the visible columns and at or below the first image row.
    a_r7_valid_window: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |-> (col < act_cfg.act_w && row >= act_cfg.first_row));

    // R8: an edge with the enable low changes no output.
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(pix_en)) |->
        ($stable(col) && $stable(row) && $stable(hsync) && $stable(vsync) && $stable(data_valid)));
endmodule

bind raster_timing_gen raster_timing_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .pix_en     (pix_en),
    .act_cfg    (act_cfg),
    .hsync      (hsync),
    .vsync      (vsync),
    .data_valid (data_valid),
    .col        (col),
    .row        (row)
);

// File: tb/raster_timing_gen_tb.sv
// Bench for raster_timing_gen.
// A behavioural model built from integers runs beside the design.
// Every output is compared with the model on each falling clock edge.
module raster_timing_gen_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pix_en = 1'b0;
    logic [15:0] t_act_w = '0, t_hblank = '0, t_hs_start = '0;
    logic [7:0]  t_hs_width = '0, t_vs_width = '0;
    logic        t_mode = 1'b0;
    logic [12:0] t_act_h = '0, t_vblank = '0, t_first_row = '0, t_vs_start = '0;
    logic        hsync, vsync, data_valid;
    logic [15:0] col;
    logic [12:0] row;

    int n_vec = 0;
    int n_bad = 0;

    raster_timing_gen dut_i (
        .clk(clk), .rst_n(rst_n), .pix_en(pix_en),
        .cfg_act_w(t_act_w), .cfg_hblank(t_hblank), .cfg_hs_start(t_hs_start),
        .cfg_hs_width(t_hs_width), .cfg_hs_valid_mode(t_mode),
        .cfg_act_h(t_act_h), .cfg_vblank(t_vblank), .cfg_first_row(t_first_row),
        .cfg_vs_start(t_vs_start), .cfg_vs_width(t_vs_width),
        .hsync(hsync), .vsync(vsync), .data_valid(data_valid), .col(col), .row(row)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model state: live position, shadowed settings, expected outputs.
    int m_col = 0, m_row = 0;
    int s_aw = 0, s_hb = 0, s_hss = 0, s_hsw = 0, s_mode = 0;
    int s_ah = 0, s_vb = 0, s_fr = 0, s_vss = 0, s_vsw = 0;
    int e_col = 0, e_row = 0, e_hs = 0, e_vs = 0, e_dv = 0;
    bit last_en = 1'b0;
    bit last_rst = 1'b1;

    task automatic take_cfg();
        s_aw = t_act_w; s_hb = t_hblank; s_hss = t_hs_start; s_hsw = t_hs_width;
        s_mode = t_mode; s_ah = t_act_h; s_vb = t_vblank; s_fr = t_first_row;
        s_vss = t_vs_start; s_vsw = t_vs_width;
    endtask

    always @(posedge clk) begin
        last_en  = pix_en;
        last_rst = !rst_n;
        if (!rst_n) begin
            m_col = 0; m_row = 0;
            e_col = 0; e_row = 0; e_hs = 0; e_vs = 0; e_dv = 0;
            take_cfg();
        end else if (pix_en) begin
            e_col = m_col;
            e_row = m_row;
            e_dv  = (m_col < s_aw && m_row >= s_fr && m_row < s_fr + s_ah) ? 1 : 0;
            e_vs  = (m_row >= s_vss && m_row < s_vss + s_vsw) ? 1 : 0;
            if (s_mode != 0) e_hs = e_dv;
            else e_hs = (m_col >= s_hss && m_col < s_hss + s_hsw) ? 1 : 0;
            if (m_col + 1 >= s_aw + s_hb) begin
                m_col = 0;
                if (m_row + 1 >= s_ah + s_vb) begin
                    m_row = 0;
                    take_cfg();
                end else begin
                    m_row = m_row + 1;
                end
            end else begin
                m_col = m_col + 1;
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp, input string what);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s at %0t: actual %0d expected %0d", req, what, $time, act, exp);
        end
    endtask

    int p_col = 0, p_row = 0, p_hs = 0, p_vs = 0, p_dv = 0;

    task automatic compare_all();
        bit pend;
        pend = (s_aw != t_act_w) || (s_hb != t_hblank) || (s_ah != t_act_h) ||
               (s_vb != t_vblank) || (s_mode != t_mode) || (s_hss != t_hs_start);
        if (last_rst) begin
            chk("R1", col, 0, "col in reset");
            chk("R1", row, 0, "row in reset");
            chk("R1", {hsync, vsync, data_valid}, 0, "syncs in reset");
        end else begin
            chk(pend ? "R9" : "R2", col, e_col, "col");
            chk(pend ? "R9" : "R3", row, e_row, "row");
            chk(s_mode != 0 ? "R5" : "R4", hsync, e_hs, "hsync");
            chk("R6", vsync, e_vs, "vsync");
            chk("R7", data_valid, e_dv, "data_valid");
            if (!last_en) begin
                chk("R8", {col, row, hsync, vsync, data_valid},
                    {p_col[15:0], p_row[12:0], p_hs[0], p_vs[0], p_dv[0]}, "hold");
            end
        end
        p_col = col; p_row = row; p_hs = hsync; p_vs = vsync; p_dv = data_valid;
    endtask

    task automatic set_cfg(input int aw, input int hb, input int hss, input int hsw,
                           input int md, input int ah, input int vb, input int fr,
                           input int vss, input int vsw);
        t_act_w = aw[15:0]; t_hblank = hb[15:0]; t_hs_start = hss[15:0];
        t_hs_width = hsw[7:0]; t_mode = md[0]; t_act_h = ah[12:0];
        t_vblank = vb[12:0]; t_first_row = fr[12:0]; t_vs_start = vss[12:0];
        t_vs_width = vsw[7:0];
    endtask

    task automatic run(input int cycles, input int en_pct);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            compare_all();
            pix_en = ($urandom_range(99) < en_pct);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        n_bad++;
        $display("FAIL watchdog expired at %0t", $time);
        finish_run();
    end

    initial begin
        // R1: configuration A is loaded while reset is held
        set_cfg(6, 4, 3, 2, 0, 4, 5, 2, 1, 2);
        @(posedge clk);
        run(5, 0);
        rst_n = 1'b1;
        // R2 R3 R4 R6 R7: continuous enable for more than two frames
        run(200, 100);
        // R8: random gaps in the enable
        run(300, 70);
        // R9 R5: configuration B arrives mid-frame, in line-valid mode
        set_cfg(5, 3, 0, 3, 1, 3, 4, 3, 5, 2);
        run(400, 80);
        // R4: configuration C puts the pulse on the last column and the frame sync on row 0
        set_cfg(4, 6, 8, 2, 0, 3, 2, 1, 0, 1);
        run(400, 60);
        // R1: reset in the middle of a run
        @(negedge clk);
        compare_all();
        rst_n = 1'b0;
        run(4, 100);
        rst_n = 1'b1;
        run(200, 90);
        finish_run();
    end
endmodule